// File: doc/BRIEF.md
# Pixel Clock Divider Search Engine

This block chooses the clock setting that brings a display pixel clock as close as possible to a requested frequency. A request in Hz and an output-type select are presented together with a one-cycle start strobe. The engine then walks a fixed set of candidate settings, one per clock cycle. Each setting is a source clock (288 MHz or 336 MHz), an odd divider, and a power-of-two shift from 0 to 7. For each one it forms the rounded output frequency, takes the absolute error against the request, and keeps the candidate with the smallest error.

When the walk ends, the chosen source index, divider, shift and achieved frequency appear on the outputs, and a one-cycle done pulse marks them valid. The achieved frequency is the truncated quotient, not the rounded value used for the comparison. Results stay unchanged between searches. A start that arrives during a search is dropped. The request and the output-type select are captured when the search starts, so changing them during a search does not affect it.

Top module: `pclk_search`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `src_sel`, `div_val`, `shift_val` and `freq_hz` are all 0.
- R2: A start sampled while idle makes `busy` high for exactly 32 cycles (`panel_sel`=0) or 48 cycles (`panel_sel`=1). `done` is then high for exactly one cycle, in the cycle right after `busy` falls.
- R3: Candidates are visited with the source outermost, the divider in the middle and the shift innermost. The source order is 288 MHz (`src_sel`=0) then 336 MHz (`src_sel`=1). The dividers step by 2 from 1: {1,3} when `panel_sel`=0 and {1,3,5} when `panel_sel`=1. The shift takes every value from 0 to 7.
- R4: Each candidate is compared using the rounded value (2·mclk + d·2^s) / (2·d·2^s) and its absolute difference from the request. A candidate is adopted only if its error is strictly below the best so far, so the earliest candidate wins a tie.
- R5: The best error starts each search at 999,999,999. If no candidate comes below that bound, the result outputs keep their previous values, and `done` still pulses.
- R6: `div_val` is the odd divider value itself. `shift_val` is the shift count. `freq_hz` is the truncated quotient mclk / (d·2^s) of the chosen candidate.
- R7: A start while `busy` is high is ignored. Changes to `req_hz` or `panel_sel` after the start do not affect the running search.
- R8: The result outputs change only at the clock edge that raises `done`, and hold their values at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (accepted only while idle) |
| req_hz | input | 32 | Requested pixel clock in Hz |
| panel_sel | input | 1 | 1 = panel target (dividers 1,3,5), 0 = CRT target (dividers 1,3) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: results valid |
| src_sel | output | 1 | Chosen source: 0 = 288 MHz, 1 = 336 MHz |
| div_val | output | 3 | Chosen odd divider |
| shift_val | output | 3 | Chosen power-of-two shift |
| freq_hz | output | 32 | Achieved frequency (truncated) in Hz |

## Verification
The assertions check the following on every cycle:
- `done` is a single-cycle pulse that follows the end of `busy`.
- The divider stays odd and inside the set allowed for the output type, and the shift steps by one.
- The captured request does not move during a search.
- The running best error never rises.
- A held result means an error below the initial bound.
- The result outputs move only together with `done`.

Only the bench scenarios can show which candidate is actually chosen. These cover:
- the panel and CRT divider sets giving different answers for the same request;
- a tie between two equally distant candidates going to the earlier one;
- an out-of-range request leaving the previous result in place;
- the exact busy lengths.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int FREQ_W = 32;
    localparam int SRC_W  = 1;
    localparam int DIV_W  = 3;
    localparam int SH_W   = 3;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
        logic [SH_W-1:0]  sh;
    } cand_t;
endpackage

// File: rtl/pcs_seq.sv
module pcs_seq
    import pcs_pkg::*;
#(
    parameter int NUM_SRC       = 2,
    parameter int NUM_SHIFT     = 8,
    parameter int DIV_MAX_CRT   = 3,
    parameter int DIV_MAX_PANEL = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] req_i,
    input  logic              panel_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              accept_o,
    output logic              last_o,
    output cand_t             cand_o,
    output logic [FREQ_W-1:0] req_o
);
    typedef struct packed {
        logic              busy;
        logic              done;
        logic              panel;
        logic [FREQ_W-1:0] req;
        cand_t             cand;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic [DIV_W-1:0] div_lim;
    logic             src_end, div_end, sh_end;

    always_comb begin
        div_lim  = seq_q.panel ? DIV_W'(DIV_MAX_PANEL) : DIV_W'(DIV_MAX_CRT);
        src_end  = (seq_q.cand.src == SRC_W'(NUM_SRC - 1));
        div_end  = (seq_q.cand.div == div_lim);
        sh_end   = (seq_q.cand.sh == SH_W'(NUM_SHIFT - 1));
        accept_o = start && !seq_q.busy;
        last_o   = seq_q.busy && src_end && div_end && sh_end;

        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (seq_q.busy) begin
            if (sh_end) begin
                seq_d.cand.sh = '0;
                if (div_end) begin
                    seq_d.cand.div = DIV_W'(1);
                    if (src_end) begin
                        seq_d.busy     = 1'b0;
                        seq_d.done     = 1'b1;
                        seq_d.cand.src = '0;
                    end else begin
                        seq_d.cand.src = seq_q.cand.src + SRC_W'(1);
                    end
                end else begin
                    seq_d.cand.div = seq_q.cand.div + DIV_W'(2);
                end
            end else begin
                seq_d.cand.sh = seq_q.cand.sh + SH_W'(1);
            end
        end else if (start) begin
            seq_d.busy     = 1'b1;
            seq_d.req      = req_i;
            seq_d.panel    = panel_i;
            seq_d.cand.src = '0;
            seq_d.cand.div = DIV_W'(1);
            seq_d.cand.sh  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy_o = seq_q.busy;
    assign done_o = seq_q.done;
    assign cand_o = seq_q.cand;
    assign req_o  = seq_q.req;

    AST_DIV_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.busy |-> (seq_q.cand.div[0] && seq_q.cand.div <= div_lim)); // R3
    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && $past(seq_q.busy) && $past(seq_q.cand.sh) != SH_W'(NUM_SHIFT - 1))
        |-> seq_q.cand.sh == $past(seq_q.cand.sh) + SH_W'(1)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |=> !seq_q.done); // R2
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |-> (!seq_q.busy && $past(seq_q.busy))); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && $past(seq_q.busy)) |-> ($stable(seq_q.req) && $stable(seq_q.panel))); // R7
endmodule

// File: rtl/pcs_eval.sv
module pcs_eval
    import pcs_pkg::*;
#(
    parameter int SRC_BASE_HZ = 288000000,
    parameter int SRC_STEP_HZ = 48000000,
    parameter int NUM_DIV     = 3
) (
    input  cand_t             cand_i,
    input  logic [FREQ_W-1:0] req_i,
    output logic [FREQ_W-1:0] err_o,
    output logic [FREQ_W-1:0] freq_o
);
    localparam int SUM_W = FREQ_W + 2;

    logic [FREQ_W-1:0] mclk;
    logic [SUM_W-1:0]  two_m, half_den, sum, scaled, rnd, req_x, diff;
    logic [SH_W:0]     rsh;
    logic [FREQ_W-1:0] trunc_pow, trc;
    logic [SUM_W-1:0]  q_rnd [NUM_DIV];
    logic [FREQ_W-1:0] q_trc [NUM_DIV];

    always_comb begin
        mclk      = FREQ_W'(SRC_BASE_HZ) + FREQ_W'(SRC_STEP_HZ) * FREQ_W'(cand_i.src);
        two_m     = SUM_W'(mclk) << 1;
        half_den  = SUM_W'(cand_i.div) << cand_i.sh;
        sum       = two_m + half_den;
        rsh       = {1'b0, cand_i.sh} + (SH_W + 1)'(1);
        scaled    = sum >> rsh;
        trunc_pow = mclk >> cand_i.sh;
    end

    for (genvar k = 0; k < NUM_DIV; k++) begin : g_odd
        assign q_rnd[k] = scaled / SUM_W'(2 * k + 1);
        assign q_trc[k] = trunc_pow / FREQ_W'(2 * k + 1);
    end

    always_comb begin
        rnd = '0;
        trc = '0;
        for (int k = 0; k < NUM_DIV; k++) begin
            if (DIV_W'(2 * k + 1) == cand_i.div) begin
                rnd = q_rnd[k];
                trc = q_trc[k];
            end
        end
        req_x  = SUM_W'(req_i);
        diff   = (req_x >= rnd) ? (req_x - rnd) : (rnd - req_x);
        err_o  = FREQ_W'(diff);
        freq_o = trc;
    end
endmodule

// File: rtl/pcs_best.sv
module pcs_best
    import pcs_pkg::*;
#(
    parameter int ERR_BOUND = 999999999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              valid_i,
    input  logic              last_i,
    input  logic              done_i,
    input  cand_t             cand_i,
    input  logic [FREQ_W-1:0] err_i,
    input  logic [FREQ_W-1:0] freq_i,
    output cand_t             res_cand_o,
    output logic [FREQ_W-1:0] res_freq_o
);
    typedef struct packed {
        logic [FREQ_W-1:0] err;
        logic              found;
        cand_t             cand;
        logic [FREQ_W-1:0] freq;
        cand_t             out_cand;
        logic [FREQ_W-1:0] out_freq;
    } best_t;

    best_t best_d, best_q;
    logic  win;

    always_comb begin
        win    = valid_i && (err_i < best_q.err);
        best_d = best_q;
        if (clear_i) begin
            best_d.err   = FREQ_W'(ERR_BOUND);
            best_d.found = 1'b0;
        end else if (valid_i) begin
            if (win) begin
                best_d.err   = err_i;
                best_d.found = 1'b1;
                best_d.cand  = cand_i;
                best_d.freq  = freq_i;
            end
            if (last_i && (win || best_q.found)) begin
                best_d.out_cand = win ? cand_i : best_q.cand;
                best_d.out_freq = win ? freq_i : best_q.freq;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_q     <= '0;
            best_q.err <= FREQ_W'(ERR_BOUND);
        end else begin
            best_q <= best_d;
        end
    end

    assign res_cand_o = best_q.out_cand;
    assign res_freq_o = best_q.out_freq;

    AST_BEST_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && $past(valid_i)) |-> best_q.err <= $past(best_q.err)); // R4
    AST_FOUND_BELOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        best_q.found |-> best_q.err < FREQ_W'(ERR_BOUND)); // R5
    AST_OUT_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |-> ($stable(best_q.out_cand) && $stable(best_q.out_freq))); // R8
endmodule

// File: rtl/pclk_search.sv
module pclk_search
    import pcs_pkg::*;
#(
    parameter int SRC_BASE_HZ   = 288000000,
    parameter int SRC_STEP_HZ   = 48000000,
    parameter int NUM_SRC       = 2,
    parameter int NUM_SHIFT     = 8,
    parameter int DIV_MAX_CRT   = 3,
    parameter int DIV_MAX_PANEL = 5,
    parameter int ERR_BOUND     = 999999999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] req_hz,
    input  logic              panel_sel,
    output logic              busy,
    output logic              done,
    output logic [SRC_W-1:0]  src_sel,
    output logic [DIV_W-1:0]  div_val,
    output logic [SH_W-1:0]   shift_val,
    output logic [FREQ_W-1:0] freq_hz
);
    localparam int NUM_DIV = (DIV_MAX_PANEL + 1) / 2;

    logic              accept, last;
    cand_t             cand, res_cand;
    logic [FREQ_W-1:0] req_q, err, cand_freq;

    pcs_seq #(
        .NUM_SRC      (NUM_SRC),
        .NUM_SHIFT    (NUM_SHIFT),
        .DIV_MAX_CRT  (DIV_MAX_CRT),
        .DIV_MAX_PANEL(DIV_MAX_PANEL)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .req_i   (req_hz),
        .panel_i (panel_sel),
        .busy_o  (busy),
        .done_o  (done),
        .accept_o(accept),
        .last_o  (last),
        .cand_o  (cand),
        .req_o   (req_q)
    );

    pcs_eval #(
        .SRC_BASE_HZ(SRC_BASE_HZ),
        .SRC_STEP_HZ(SRC_STEP_HZ),
        .NUM_DIV    (NUM_DIV)
    ) u_eval (
        .cand_i(cand),
        .req_i (req_q),
        .err_o (err),
        .freq_o(cand_freq)
    );

    pcs_best #(
        .ERR_BOUND(ERR_BOUND)
    ) u_best (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (accept),
        .valid_i   (busy),
        .last_i    (last),
        .done_i    (done),
        .cand_i    (cand),
        .err_i     (err),
        .freq_i    (cand_freq),
        .res_cand_o(res_cand),
        .res_freq_o(freq_hz)
    );

    assign src_sel   = res_cand.src;
    assign div_val   = res_cand.div;
    assign shift_val = res_cand.sh;
endmodule

// File: tb/pclk_search_tb.sv
module pclk_search_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] req_hz = '0;
    logic        panel_sel = 1'b0;
    logic        busy, done;
    logic [0:0]  src_sel;
    logic [2:0]  div_val, shift_val;
    logic [31:0] freq_hz;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pclk_search u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_hz(req_hz),
        .panel_sel(panel_sel), .busy(busy), .done(done), .src_sel(src_sel),
        .div_val(div_val), .shift_val(shift_val), .freq_hz(freq_hz)
    );

    function automatic void ref_search(input longint req, input bit pnl, output bit fnd,
                                       output int rs, output int rd, output int rsh,
                                       output longint rf);
        longint best, m, den, r, e;
        best = 999999999;
        fnd = 0; rs = 0; rd = 0; rsh = 0; rf = 0;
        for (int s = 0; s < 2; s++)
            for (int d = 1; d <= (pnl ? 5 : 3); d += 2)
                for (int h = 0; h < 8; h++) begin
                    m   = 288000000 + 48000000 * s;
                    den = longint'(d) << h;
                    r   = (2 * m + den) / (2 * den);
                    e   = (r > req) ? r - req : req - r;
                    if (e < best) begin
                        best = e; fnd = 1; rs = s; rd = d; rsh = h; rf = m / den;
                    end
                end
    endfunction

    // behavioural reference model, advanced on each rising edge
    bit     m_busy, m_done, p_found;
    int     m_cnt, m_src, m_div, m_sh, p_src, p_div, p_sh;
    longint m_freq, p_freq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_cnt <= 0;
            m_src <= 0; m_div <= 0; m_sh <= 0; m_freq <= 0;
        end else begin
            m_done <= 0;
            if (m_busy) begin
                if (m_cnt == 1) begin
                    m_busy <= 0;
                    m_done <= 1;
                    if (p_found) begin
                        m_src <= p_src; m_div <= p_div; m_sh <= p_sh; m_freq <= p_freq;
                    end
                end
                m_cnt <= m_cnt - 1;
            end else if (start) begin
                m_busy <= 1;
                m_cnt  <= panel_sel ? 48 : 32;
                ref_search(longint'(req_hz), panel_sel, p_found, p_src, p_div, p_sh, p_freq);
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (busy !== m_busy || done !== m_done) begin
                failures++;
                $display("FAIL R2 busy/done act=%0b/%0b exp=%0b/%0b", busy, done, m_busy, m_done);
            end
            checks++;
            if (int'(src_sel) != m_src || int'(div_val) != m_div ||
                int'(shift_val) != m_sh || longint'(freq_hz) != m_freq) begin
                failures++;
                $display("FAIL R8 result act=%0d/%0d/%0d/%0d exp=%0d/%0d/%0d/%0d",
                         src_sel, div_val, shift_val, freq_hz, m_src, m_div, m_sh, m_freq);
            end
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_res(input string tag, input int s, input int d, input int h, input longint f);
        chk({tag, " src"}, longint'(src_sel), s);
        chk({tag, " div"}, longint'(div_val), d);
        chk({tag, " shift"}, longint'(shift_val), h);
        chk({tag, " freq"}, longint'(freq_hz), f);
    endtask

    task automatic run_search(input logic [31:0] rq, input bit pnl, output int nb);
        @(negedge clk);
        req_hz = rq; panel_sel = pnl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nb = 0;
        while (!done) begin
            if (busy) nb++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int nb;
        repeat (4) @(negedge clk);
        chk("R1 busy", longint'(busy), 0);
        chk("R1 done", longint'(done), 0);
        chk_res("R1 reset", 0, 0, 0, 0);
        rst_n = 1'b1;

        run_search(32'd40000000, 1'b0, nb);
        chk("R2 crt busy cycles", nb, 32);
        chk_res("R3 crt 40M", 1, 1, 3, 42000000);
        @(negedge clk);
        chk("R2 done single cycle", longint'(done), 0);

        run_search(32'd57600000, 1'b1, nb);
        chk("R2 panel busy cycles", nb, 48);
        chk_res("R3 panel divider 5", 0, 5, 0, 57600000);

        run_search(32'd57600000, 1'b0, nb);
        chk_res("R3 crt excludes 5", 1, 3, 1, 56000000);

        run_search(32'd39000000, 1'b0, nb);
        chk_res("R4 tie earliest", 0, 1, 3, 36000000);

        run_search(32'd40000000, 1'b0, nb);
        run_search(32'd2000000000, 1'b0, nb);
        chk("R5 done pulsed", longint'(done), 1);
        chk_res("R5 bound keeps previous", 1, 1, 3, 42000000);

        run_search(32'd0, 1'b0, nb);
        chk_res("R6 crt lowest", 0, 3, 7, 750000);
        run_search(32'd0, 1'b1, nb);
        chk_res("R6 panel lowest", 0, 5, 7, 450000);

        // R7: second start and input changes during a search are ignored
        @(negedge clk);
        req_hz = 32'd40000000; panel_sel = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nb = 0;
        repeat (3) begin
            if (busy) nb++;
            @(negedge clk);
        end
        req_hz = 32'd57600000; panel_sel = 1'b1; start = 1'b1;
        if (busy) nb++;
        @(negedge clk);
        start = 1'b0;
        while (!done) begin
            if (busy) nb++;
            @(negedge clk);
        end
        chk("R7 busy cycles", nb, 32);
        chk_res("R7 result of first start", 1, 1, 3, 42000000);

        // R8: results hold while idle
        repeat (20) @(negedge clk);
        chk("R8 idle done", longint'(done), 0);
        chk_res("R8 idle hold", 1, 1, 3, 42000000);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule